// File: doc/BRIEF.md
# Capture/Compare Timer Channel

This block is one channel of a timer. It watches a shared free-running 16-bit count that is supplied from outside and holds a single 16-bit register. A control bit gives that register one of two jobs. In capture mode, the channel records the count at the moment a chosen edge arrives on its input pin. In compare mode, the channel checks the register against the count on every clock. When the two are equal it raises a status flag and can also change its output pin.

Software uses the channel through a small register port. Writes are 16 bits wide and take effect at the next clock edge. Reads are combinational. To generate a pulse in compare mode, software:

1. Writes the start time and a "drive high" action.
2. Waits for the flag.
3. Writes the start time plus the pulse width together with a "drive low" action.

Top module: `cct_timer_channel`

## Requirements
- R1: After reset, the value register reads 16'hFFFF, the control register reads 0, and the flag, `pin_o` and `pin_oe` are all 0.
- R2: The register port uses three addresses:
  - Address 0 is the 16-bit value register.
  - Address 1 is control: bit 0 is the capture-mode select (1 = capture, 0 = compare), bits 2:1 are the pin action and bits 4:3 are the edge select. Unused bits read back as 0.
  - Address 2 is status: bit 0 is the flag.
- R3: In compare mode, if the value register equals `cnt_i` during a cycle, the flag is set at the clock edge that ends that cycle. It is not set earlier.
- R4: On that same edge the pin action is applied, using the encoding 00 = no change, 01 = invert, 10 = drive 0, 11 = drive 1. `pin_oe` is 1 only in compare mode with a nonzero action. Without a match, `pin_o` keeps its value.
- R5: The flag stays set until software writes 1 to bit 0 of address 2. Writing 0 to that bit has no effect.
- R6: If a clear write and a new match or capture happen in the same cycle, the flag stays set.
- R7: In capture mode, `pin_oe` is 0. A count equal to the register neither sets the flag nor changes `pin_o`.
- R8: The capture edge select uses the encoding 00 = off, 01 = rising, 10 = falling, 11 = both. Edges that the selection excludes leave both the register and the flag unchanged.
- R9: The pin passes through a two-flop synchronizer. Take an edge first sampled at clock edge k. The count present between edges k+1 and k+2 is loaded at edge k+2, and the flag is set at that same edge.
- R10: To form a pulse, software rewrites the register and the action after the first match. The pin then returns to the opposite level at the second match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_i | input | 16 | Shared free-running count |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Read data (combinational) |
| pin_i | input | 1 | Capture pin input (asynchronous) |
| pin_o | output | 1 | Compare pin output level |
| pin_oe | output | 1 | Compare pin output enable |
| flag_o | output | 1 | Status flag |

## Verification
Each internal fault shows up at the ports at a predictable time:
- A bad comparator or a corrupted value register shows on `flag_o` and `pin_o` one clock after the count that should have matched. It also shows at once on a read of address 0.
- A synchronizer with the wrong depth moves the loaded count by one step, so the value read back after a capture differs from the count two cycles after the pin changed.
- Mode gating faults show within a cycle as `pin_oe` or the flag misbehaving while capture is selected.

// File: rtl/cct_pkg.sv
`timescale 1ns/1ps
package cct_pkg;
  localparam logic [1:0] A_VAL  = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;

  typedef enum logic [1:0] {ACT_OFF = 2'd0, ACT_TOG = 2'd1, ACT_LOW = 2'd2, ACT_HIGH = 2'd3} act_e;
  typedef enum logic [1:0] {EDG_NONE = 2'd0, EDG_RISE = 2'd1, EDG_FALL = 2'd2, EDG_BOTH = 2'd3} edg_e;

  typedef struct packed {
    edg_e edg;
    act_e act;
    logic cap;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  function automatic logic pin_next(act_e a, logic cur);
    case (a)
      ACT_TOG:  return ~cur;
      ACT_LOW:  return 1'b0;
      ACT_HIGH: return 1'b1;
      default:  return cur;
    endcase
  endfunction

  function automatic logic edge_seen(edg_e s, logic prev, logic now);
    case (s)
      EDG_RISE: return now & ~prev;
      EDG_FALL: return prev & ~now;
      EDG_BOTH: return now ^ prev;
      default:  return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/cct_sync_edge.sv
`timescale 1ns/1ps
module cct_sync_edge
  import cct_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  edg_e sel,
  output logic hit
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], pin_i};
  end

  assign hit = edge_seen(sel, chain[STAGES], chain[STAGES-1]);
endmodule

// File: rtl/cct_compare.sv
`timescale 1ns/1ps
module cct_compare #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         en,
  output logic         hit
);
  logic [W-1:0] same;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign same[i] = ~(a[i] ^ b[i]);
  end

  assign hit = en & (&same);
endmodule

// File: rtl/cct_pin_drive.sv
`timescale 1ns/1ps
module cct_pin_drive
  import cct_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  act_e act,
  output logic pin_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pin_q <= 1'b0;
    else if (fire) pin_q <= pin_next(act, pin_q);
  end
endmodule

// File: rtl/cct_timer_channel.sv
`timescale 1ns/1ps
module cct_timer_channel
  import cct_pkg::*;
#(
  parameter int unsigned W           = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt_i,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   rd_addr,
  output logic [W-1:0] rd_data,
  input  logic         pin_i,
  output logic         pin_o,
  output logic         pin_oe,
  output logic         flag_o
);
  localparam int unsigned PAD_W = W - CTRL_W;

  ctrl_t        ctrl_q;
  logic [W-1:0] val_q;
  logic         flag_q;

  logic wr_val, wr_ctrl, clr_req;
  logic cmp_hit, edge_hit, cap_hit, evt_hit;

  assign wr_val  = wr_en && (wr_addr == A_VAL);
  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
  assign clr_req = wr_en && (wr_addr == A_STAT) && wr_data[0];

  cct_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i (pin_i),
    .sel   (ctrl_q.edg),
    .hit   (edge_hit)
  );

  cct_compare #(.W(W)) u_cmp (
    .a   (val_q),
    .b   (cnt_i),
    .en  (~ctrl_q.cap),
    .hit (cmp_hit)
  );

  cct_pin_drive u_pin (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (cmp_hit),
    .act   (ctrl_q.act),
    .pin_q (pin_o)
  );

  assign cap_hit = ctrl_q.cap & edge_hit;
  assign evt_hit = cmp_hit | cap_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= '1;
      ctrl_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (cap_hit)     val_q <= cnt_i;
      else if (wr_val) val_q <= wr_data;
      if (wr_ctrl)     ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
      if (evt_hit)      flag_q <= 1'b1;
      else if (clr_req) flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign pin_oe = ~ctrl_q.cap && (ctrl_q.act != ACT_OFF);

  always_comb begin
    case (rd_addr)
      A_VAL:   rd_data = val_q;
      A_CTRL:  rd_data = {{PAD_W{1'b0}}, ctrl_q};
      A_STAT:  rd_data = {{(W-1){1'b0}}, flag_q};
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/cct_timer_checker.sv
`timescale 1ns/1ps
module cct_timer_checker #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] cnt_i,
  input logic [W-1:0] val_q,
  input logic         cap_mode,
  input logic         cmp_hit,
  input logic         cap_hit,
  input logic         clr_req,
  input logic         flag_o,
  input logic         pin_o,
  input logic         pin_oe
);
  p_match_sets_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_hit |=> flag_o);

  p_pin_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_hit |=> $stable(pin_o));

  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_req) |=> flag_o);

  p_set_beats_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmp_hit || cap_hit) && clr_req) |=> flag_o);

  p_capture_no_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_mode |-> (!pin_oe && !cmp_hit));

  p_capture_loads_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hit |=> (val_q == $past(cnt_i) && flag_o));
endmodule

bind cct_timer_channel cct_timer_checker #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnt_i    (cnt_i),
  .val_q    (val_q),
  .cap_mode (ctrl_q.cap),
  .cmp_hit  (cmp_hit),
  .cap_hit  (cap_hit),
  .clr_req  (clr_req),
  .flag_o   (flag_o),
  .pin_o    (pin_o),
  .pin_oe   (pin_oe)
);

// File: tb/test_cct_timer_channel.sv
`timescale 1ns/1ps
module test_cct_timer_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt_i = 16'h0000;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'h0000;
  logic [1:0]  rd_addr = 2'd0;
  logic        pin_i = 1'b0;
  wire  [15:0] rd_data;
  wire         pin_o, pin_oe, flag_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  // observation selectors
  localparam int OBS_RD = 0, OBS_FLAG = 1, OBS_PIN = 2, OBS_OE = 3;

  typedef struct {
    string       tag;
    int          sel;
    logic [15:0] exp;
  } item_t;

  item_t sb_q[$];
  event  push_ev;

  always #2.5 clk = ~clk;

  cct_timer_channel i_cct_timer_channel (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe), .flag_o(flag_o)
  );

  // monitor: pops expected items and compares with the ports
  initial begin : monitor
    item_t       it;
    logic [15:0] act;
    forever begin
      @(push_ev);
      #0.1;
      while (sb_q.size() != 0) begin
        it = sb_q.pop_front();
        case (it.sel)
          OBS_RD:   act = rd_data;
          OBS_FLAG: act = {15'd0, flag_o};
          OBS_PIN:  act = {15'd0, pin_o};
          default:  act = {15'd0, pin_oe};
        endcase
        n_chk++;
        if (act !== it.exp) begin
          n_err++;
          $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  // driver side
  task automatic expect_item(string tag, int sel, logic [1:0] addr, logic [15:0] e);
    item_t it;
    rd_addr = addr;
    it.tag = tag;
    it.sel = sel;
    it.exp = e;
    sb_q.push_back(it);
    -> push_ev;
    #0.2;
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    wr_en = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // pin change, then count advances; loaded value is base+2 (R9)
  task automatic cap_seq(logic lvl, logic [15:0] base, logic [15:0] old_val, string tag);
    pin_i = lvl;
    cnt_i = base;
    step(1);
    cnt_i = base + 16'd1;
    step(1);
    expect_item({tag, " before load"}, OBS_RD, 2'd0, old_val);
    cnt_i = base + 16'd2;
    step(1);
  endtask

  initial begin : watchdog
    #20000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%h expected=%h", 1'b0, 1'b1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin : main
    step(3);
    rst_n = 1'b1;
    // R1 reset state
    expect_item("R1 value", OBS_RD, 2'd0, 16'hFFFF);
    expect_item("R1 ctrl", OBS_RD, 2'd1, 16'h0000);
    expect_item("R1 flag", OBS_FLAG, 2'd0, 16'd0);
    expect_item("R1 pin", OBS_PIN, 2'd0, 16'd0);
    expect_item("R1 oe", OBS_OE, 2'd0, 16'd0);

    // R2 control readback: compare mode, drive-1 action
    wr(2'd1, 16'hFFE6);
    expect_item("R2 ctrl readback", OBS_RD, 2'd1, 16'h0006);
    wr(2'd0, 16'h0100);
    expect_item("R2 value readback", OBS_RD, 2'd0, 16'h0100);
    expect_item("R3 no early flag", OBS_FLAG, 2'd0, 16'd0);
    expect_item("R4 oe in compare", OBS_OE, 2'd0, 16'd1);

    // R3/R4 match
    cnt_i = 16'h0100;
    step(1);
    expect_item("R3 flag on match", OBS_FLAG, 2'd0, 16'd1);
    expect_item("R2 status read", OBS_RD, 2'd2, 16'h0001);
    expect_item("R4 drive 1", OBS_PIN, 2'd0, 16'd1);

    // R5 sticky flag
    cnt_i = 16'h0101;
    step(2);
    expect_item("R5 sticky", OBS_FLAG, 2'd0, 16'd1);
    wr(2'd2, 16'h0000);
    expect_item("R5 write 0 ignored", OBS_FLAG, 2'd0, 16'd1);
    wr(2'd2, 16'h0001);
    expect_item("R5 write 1 clears", OBS_FLAG, 2'd0, 16'd0);

    // R10 pulse trailing edge: new time with drive-0 action
    wr(2'd1, 16'h0004);
    wr(2'd0, 16'h0110);
    expect_item("R10 pulse still high", OBS_PIN, 2'd0, 16'd1);
    cnt_i = 16'h0110;
    step(1);
    expect_item("R10 pulse ends", OBS_PIN, 2'd0, 16'd0);
    expect_item("R10 flag", OBS_FLAG, 2'd0, 16'd1);

    // R6 clear and match in the same cycle
    cnt_i = 16'h0111;
    wr(2'd2, 16'h0001);
    expect_item("R6 pre-clear", OBS_FLAG, 2'd0, 16'd0);
    cnt_i = 16'h0110;
    wr(2'd2, 16'h0001);
    expect_item("R6 set beats clear", OBS_FLAG, 2'd0, 16'd1);

    // R4 invert action
    cnt_i = 16'h0111;
    wr(2'd1, 16'h0002);
    cnt_i = 16'h0110;
    step(1);
    expect_item("R4 invert up", OBS_PIN, 2'd0, 16'd1);
    cnt_i = 16'h0111;
    step(1);
    cnt_i = 16'h0110;
    step(1);
    expect_item("R4 invert down", OBS_PIN, 2'd0, 16'd0);

    // R4 no-change action holds a driven 1
    cnt_i = 16'h0111;
    wr(2'd1, 16'h0006);
    cnt_i = 16'h0110;
    step(1);
    cnt_i = 16'h0111;
    wr(2'd1, 16'h0000);
    wr(2'd2, 16'h0001);
    expect_item("R4 off oe", OBS_OE, 2'd0, 16'd0);
    cnt_i = 16'h0110;
    step(1);
    expect_item("R4 off flag", OBS_FLAG, 2'd0, 16'd1);
    expect_item("R4 off pin held", OBS_PIN, 2'd0, 16'd1);

    // R7 capture mode inhibits compare
    cnt_i = 16'h0111;
    wr(2'd2, 16'h0001);
    wr(2'd1, 16'h000F);
    expect_item("R7 oe off", OBS_OE, 2'd0, 16'd0);
    cnt_i = 16'h0110;
    step(2);
    expect_item("R7 no flag", OBS_FLAG, 2'd0, 16'd0);
    expect_item("R7 pin held", OBS_PIN, 2'd0, 16'd1);

    // R8/R9 rising capture
    cap_seq(1'b1, 16'h2000, 16'h0110, "R9 rise");
    expect_item("R9 rise value", OBS_RD, 2'd0, 16'h2002);
    expect_item("R9 rise flag", OBS_FLAG, 2'd0, 16'd1);
    wr(2'd2, 16'h0001);
    cap_seq(1'b0, 16'h2100, 16'h2002, "R8 fall ignored");
    step(2);
    expect_item("R8 fall ignored value", OBS_RD, 2'd0, 16'h2002);
    expect_item("R8 fall ignored flag", OBS_FLAG, 2'd0, 16'd0);

    // R8 falling select
    wr(2'd1, 16'h0011);
    cap_seq(1'b1, 16'h2200, 16'h2002, "R8 rise ignored");
    step(2);
    expect_item("R8 rise ignored flag", OBS_FLAG, 2'd0, 16'd0);
    cap_seq(1'b0, 16'h3000, 16'h2002, "R9 fall");
    expect_item("R9 fall value", OBS_RD, 2'd0, 16'h3002);
    expect_item("R9 fall flag", OBS_FLAG, 2'd0, 16'd1);

    // R8 both edges
    wr(2'd1, 16'h0019);
    wr(2'd2, 16'h0001);
    cap_seq(1'b1, 16'h4000, 16'h3002, "R8 both rise");
    expect_item("R8 both rise value", OBS_RD, 2'd0, 16'h4002);
    wr(2'd2, 16'h0001);
    cap_seq(1'b0, 16'h5000, 16'h4002, "R8 both fall");
    expect_item("R8 both fall value", OBS_RD, 2'd0, 16'h5002);
    expect_item("R8 both fall flag", OBS_FLAG, 2'd0, 16'd1);

    // R8 disabled
    wr(2'd1, 16'h0001);
    wr(2'd2, 16'h0001);
    cap_seq(1'b1, 16'h6000, 16'h5002, "R8 off");
    step(2);
    expect_item("R8 off value", OBS_RD, 2'd0, 16'h5002);
    expect_item("R8 off flag", OBS_FLAG, 2'd0, 16'd0);

    step(2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule